// File: doc/BRIEF.md
# PHY Test-Code Configuration Port

This block is the configuration slave inside a receive PHY. Software drives it over a slow test interface that it toggles by hand. The interface carries a test clock, a test enable, a test clear and an 8-bit data bus, and it returns an 8-bit read-back bus. One byte bus carries both the address and the data:

- A falling test-clock edge taken while enable is high latches the bus as the current test code, which acts as the internal address.
- A later rising edge taken while enable is low writes the bus into the configuration register that the code selects.

Between accesses the test clock rests high.

All test inputs cross into the system clock domain through a two-flop synchronizer, and edge detection happens in that domain. Each input change therefore takes effect on the third rising system-clock edge after it. Six registers are held:

| Test code | Register |
|---|---|
| 0x34 | Clock-lane receive control |
| 0x44, 0x54, 0x84, 0x94 | Receive control for data lanes 0 to 3 |
| 0x75 | Settle-time control |

Every register drives an output port. For each data lane, bits 6:1 of its receive-control byte are also brought out as a 6-bit frequency-range code. Test code 0x00 selects normal operation.

Top module: `tcfg_port`

## Requirements
- R1: After reset the current code is 0x00, all six registers read 0x00, tdout_o is 0x00 and normal_o is 1.
- R2: A falling edge of tck_i seen while ten_i is 1 latches tdin_i as the current code. The effect appears on outputs after the third rising clk_i edge following the input change.
- R3: A rising edge of tck_i seen while ten_i is 0 writes tdin_i into the register that the current code selects. The codes are 0x34 (clock lane), 0x44/0x54/0x84/0x94 (data lanes 0..3, at bytes 0..3 of lane_ctrl_o) and 0x75 (settle).
- R4: A rising edge of tck_i while ten_i is 1 writes nothing.
- R5: A falling edge of tck_i while ten_i is 0 leaves the current code unchanged.
- R6: A write under a code other than the six listed in R3 changes no register. For such a code tdout_o reads 0x00.
- R7: tdout_o shows the contents of the register that the current code selects.
- R8: For each data lane i, lane_freq_o[6i+5:6i] equals bits 6:1 of that lane's receive-control byte.
- R9: While tclr_i is held high, the current code returns to 0x00 and all registers return to 0x00.
- R10: normal_o is 1 exactly when the current code is 0x00. Writing code 0x00 therefore returns the port to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Test clock, rests at 1 |
| ten_i | input | 1 | Test enable: 1 for an address phase, 0 for a data phase |
| tclr_i | input | 1 | Test clear, active high |
| tdin_i | input | 8 | Test data bus carrying the code or the data |
| tdout_o | output | 8 | Read-back of the register the current code selects |
| normal_o | output | 1 | High when the current code is 0x00 |
| clk_lane_ctrl_o | output | 8 | Clock-lane receive control register |
| lane_ctrl_o | output | 8*NUM_LANES | Data-lane receive control registers, lane 0 in the low byte |
| lane_freq_o | output | 6*NUM_LANES | Frequency-range code per data lane, taken from bits 6:1 |
| settle_ctrl_o | output | 8 | Settle-time control register |

## Verification
The bench first runs full code-then-data accesses to every implemented register, using distinct data bytes. This separates correct decoding from aliasing between lanes and shows bits 6:1 on each lane's frequency output.

Stray edges come next:
- a rising edge with enable still high;
- a falling edge with enable low;
- an access to an unimplemented code.

These separate enable-qualified edge decoding from plain edge counting.

Last come a clear pulse, the return to code 0x00, and a write after the clear. Together they distinguish a true reset of both the code and the register state from a read-back mask.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned FW = 6;
  typedef logic [DW-1:0] byte_t;

  localparam byte_t CODE_NORMAL = 8'h00;
  localparam byte_t CODE_CLK    = 8'h34;
  localparam byte_t CODE_SETTLE = 8'h75;

  typedef struct packed {
    logic  clr;
    logic  en;
    logic  tck;
    byte_t din;
  } tbus_t;

  localparam tbus_t IDLE_BUS = '{clr: 1'b0, en: 1'b0, tck: 1'b1, din: '0};

  function automatic byte_t lane_code(input int unsigned idx);
    case (idx)
      0:       return 8'h44;
      1:       return 8'h54;
      2:       return 8'h84;
      default: return 8'h94;
    endcase
  endfunction
endpackage

// File: rtl/tcfg_sync.sv
module tcfg_sync #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tcfg_ctrl.sv
module tcfg_ctrl import tcfg_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  tbus_t bus_i,
  output logic  cap_o,
  output logic  we_o,
  output byte_t code_o
);
  logic  tck_prev_q;
  byte_t code_q;
  logic  fall, rise;

  assign fall  = tck_prev_q & ~bus_i.tck;
  assign rise  = ~tck_prev_q & bus_i.tck;
  // clear dominates both phases
  assign cap_o = fall & bus_i.en & ~bus_i.clr;
  assign we_o  = rise & ~bus_i.en & ~bus_i.clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_prev_q <= 1'b1;
      code_q     <= CODE_NORMAL;
    end else begin
      tck_prev_q <= bus_i.tck;
      if (bus_i.clr)  code_q <= CODE_NORMAL;
      else if (cap_o) code_q <= bus_i.din;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/tcfg_regfile.sv
module tcfg_regfile import tcfg_pkg::*; #(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned NUM_REGS = NUM_LANES + 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         we_i,
  input  byte_t                        code_i,
  input  byte_t                        wdata_i,
  output logic [NUM_REGS-1:0][DW-1:0]  regs_o,
  output byte_t                        rdata_o
);
  logic [NUM_REGS-1:0] hit;

  // slot 0: clock lane, slot 1: settle, slots 2..: data lanes
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam byte_t RCODE = (k == 0) ? CODE_CLK :
                              (k == 1) ? CODE_SETTLE : lane_code(k - 2);
    byte_t val_q;

    assign hit[k] = (code_i == RCODE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             val_q <= '0;
      else if (clr_i)          val_q <= '0;
      else if (we_i && hit[k]) val_q <= wdata_i;
    end

    assign regs_o[k] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (hit[k]) rdata_o = rdata_o | regs_o[k];
  end
endmodule

// File: rtl/tcfg_port.sv
module tcfg_port import tcfg_pkg::*; #(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tck_i,
  input  logic                    ten_i,
  input  logic                    tclr_i,
  input  logic [7:0]              tdin_i,
  output logic [7:0]              tdout_o,
  output logic                    normal_o,
  output logic [7:0]              clk_lane_ctrl_o,
  output logic [8*NUM_LANES-1:0]  lane_ctrl_o,
  output logic [6*NUM_LANES-1:0]  lane_freq_o,
  output logic [7:0]              settle_ctrl_o
);
  localparam int unsigned NUM_REGS = NUM_LANES + 2;
  localparam int unsigned BW       = $bits(tbus_t);

  tbus_t raw_bus, s_bus;
  logic [BW-1:0] s_vec;
  logic  clr_s, cap, we;
  byte_t din_s, code;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  assign raw_bus = '{clr: tclr_i, en: ten_i, tck: tck_i, din: tdin_i};

  tcfg_sync #(.W(BW), .RST_VAL(IDLE_BUS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (s_vec)
  );

  assign s_bus = tbus_t'(s_vec);
  assign clr_s = s_bus.clr;
  assign din_s = s_bus.din;

  tcfg_ctrl u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (s_bus),
    .cap_o (cap),
    .we_o  (we),
    .code_o(code)
  );

  tcfg_regfile #(.NUM_LANES(NUM_LANES)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_s),
    .we_i   (we),
    .code_i (code),
    .wdata_i(din_s),
    .regs_o (regs),
    .rdata_o(tdout_o)
  );

  assign normal_o        = (code == CODE_NORMAL);
  assign clk_lane_ctrl_o = regs[0];
  assign settle_ctrl_o   = regs[1];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_ctrl_o[i*DW +: DW] = regs[i+2];
    assign lane_freq_o[i*FW +: FW] = regs[i+2][FW:1];
  end
endmodule

// File: rtl/tcfg_port_chk.sv
module tcfg_port_chk #(
  parameter int unsigned NUM_LANES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   clr_s,
  input logic                   cap,
  input logic                   we,
  input logic [7:0]             din_s,
  input logic [7:0]             code,
  input logic [7:0]             tdout_o,
  input logic [7:0]             clk_lane_ctrl_o,
  input logic [8*NUM_LANES-1:0] lane_ctrl_o,
  input logic [7:0]             settle_ctrl_o
);
  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (code == 8'h00) && (clk_lane_ctrl_o == 8'h00) &&
              (lane_ctrl_o == '0) && (settle_ctrl_o == 8'h00));

  a_r2_capture_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> code == $past(din_s));

  a_r5_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap && !clr_s) |=> $stable(code));

  a_r4_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we && !clr_s) |=> $stable(lane_ctrl_o) && $stable(clk_lane_ctrl_o) &&
                        $stable(settle_ctrl_o));

  a_r3_clk_lane_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && code == 8'h34) |=> clk_lane_ctrl_o == $past(din_s));

  // every lane code ends in nibble 4; others must read zero
  a_r6_unimpl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != 8'h34 && code != 8'h75 && code[3:0] != 4'h4) |-> tdout_o == 8'h00);
endmodule

bind tcfg_port tcfg_port_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clr_s          (clr_s),
  .cap            (cap),
  .we             (we),
  .din_s          (din_s),
  .code           (code),
  .tdout_o        (tdout_o),
  .clk_lane_ctrl_o(clk_lane_ctrl_o),
  .lane_ctrl_o    (lane_ctrl_o),
  .settle_ctrl_o  (settle_ctrl_o)
);

// File: tb/tcfg_port_test.sv
`timescale 1ns/1ps
module tcfg_port_test;
  localparam int NL = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tck_i = 1'b1, ten_i = 1'b0, tclr_i = 1'b0;
  logic [7:0] tdin_i = 8'h00;
  logic [7:0] tdout_o, clk_lane_ctrl_o, settle_ctrl_o;
  logic normal_o;
  logic [8*NL-1:0] lane_ctrl_o;
  logic [6*NL-1:0] lane_freq_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tcfg_port #(.NUM_LANES(NL)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tck_i(tck_i), .ten_i(ten_i),
    .tclr_i(tclr_i), .tdin_i(tdin_i), .tdout_o(tdout_o), .normal_o(normal_o),
    .clk_lane_ctrl_o(clk_lane_ctrl_o), .lane_ctrl_o(lane_ctrl_o),
    .lane_freq_o(lane_freq_o), .settle_ctrl_o(settle_ctrl_o)
  );

  // ---------------- reference model ----------------
  logic [10:0] hist[$];
  logic [7:0]  m_mem[256];
  logic [7:0]  m_code;

  function automatic bit impl(input logic [7:0] c);
    return c == 8'h34 || c == 8'h75 || c == 8'h44 || c == 8'h54 ||
           c == 8'h84 || c == 8'h94;
  endfunction

  function automatic logic [7:0] lcode(input int i);
    case (i) 0: return 8'h44; 1: return 8'h54; 2: return 8'h84; default: return 8'h94; endcase
  endfunction

  task automatic model_reset();
    hist = {};
    for (int i = 0; i < 4; i++) hist.push_back({1'b0, 1'b0, 1'b1, 8'h00});
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_code = 8'h00;
  endtask

  initial model_reset();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      logic [10:0] s, p;
      hist.push_front({tclr_i, ten_i, tck_i, tdin_i});
      void'(hist.pop_back());
      s = hist[2];
      p = hist[3];
      if (s[10]) begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_code = 8'h00;
      end else if (p[8] && !s[8] && s[9]) m_code = s[7:0];
      else if (!p[8] && s[8] && !s[9] && impl(m_code)) m_mem[m_code] = s[7:0];
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cmp("R7", "tdout", tdout_o, impl(m_code) ? m_mem[m_code] : 8'h00);
      cmp("R10", "normal", normal_o, m_code == 8'h00);
      cmp("R3", "clk_lane", clk_lane_ctrl_o, m_mem[8'h34]);
      cmp("R3", "settle", settle_ctrl_o, m_mem[8'h75]);
      for (int i = 0; i < NL; i++) begin
        cmp("R3", "lane_ctrl", lane_ctrl_o[i*8 +: 8], m_mem[lcode(i)]);
        cmp("R8", "lane_freq", lane_freq_o[i*6 +: 6], m_mem[lcode(i)][6:1]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic settle_wait();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic latch_code(input logic [7:0] c);
    tdin_i = c; ten_i = 1'b1; settle_wait();
    tck_i = 1'b0; settle_wait();
  endtask

  task automatic write_data(input logic [7:0] d);
    ten_i = 1'b0; settle_wait();
    tdin_i = d; settle_wait();
    tck_i = 1'b1; settle_wait();
  endtask

  task automatic access(input logic [7:0] c, input logic [7:0] d);
    latch_code(c);
    write_data(d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    cmp("R1", "reset tdout", tdout_o, 8'h00);
    cmp("R1", "reset normal", normal_o, 1);
    cmp("R1", "reset lanes", lane_ctrl_o, 0);

    // R2/R3 latency: code change visible on the third edge, not before
    tdin_i = 8'h44; ten_i = 1'b1; settle_wait();
    tck_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    cmp("R2", "code not yet latched", normal_o, 1);
    @(negedge clk_i);
    cmp("R2", "code latched on third edge", normal_o, 0);
    settle_wait();
    write_data(8'h5A);
    cmp("R3", "lane0 write", lane_ctrl_o[7:0], 8'h5A);
    cmp("R8", "lane0 freq", lane_freq_o[5:0], 6'h2D);
    cmp("R7", "readback lane0", tdout_o, 8'h5A);

    access(8'h34, 8'h11);
    access(8'h54, 8'h22);
    access(8'h84, 8'h7E);
    access(8'h94, 8'h80);
    access(8'h75, 8'h04);
    cmp("R3", "clk lane write", clk_lane_ctrl_o, 8'h11);
    cmp("R3", "lane3 write", lane_ctrl_o[31:24], 8'h80);
    cmp("R8", "lane3 freq", lane_freq_o[23:18], 6'h00);
    cmp("R8", "lane2 freq", lane_freq_o[17:12], 6'h3F);
    cmp("R7", "readback settle", tdout_o, 8'h04);

    // R4: rising edge with enable high writes nothing
    latch_code(8'h54);
    tdin_i = 8'hFF; settle_wait();
    tck_i = 1'b1; settle_wait();
    cmp("R4", "lane1 unchanged", lane_ctrl_o[15:8], 8'h22);
    cmp("R4", "readback lane1", tdout_o, 8'h22);

    // R5: falling edge with enable low keeps the code
    ten_i = 1'b0; tdin_i = 8'h84; settle_wait();
    tck_i = 1'b0; settle_wait();
    cmp("R5", "code kept (reads lane1)", tdout_o, 8'h22);
    tdin_i = 8'h33; settle_wait();
    tck_i = 1'b1; settle_wait();
    cmp("R5", "write lands in lane1", lane_ctrl_o[15:8], 8'h33);
    cmp("R5", "lane2 untouched", lane_ctrl_o[23:16], 8'h7E);

    // R6: unimplemented code
    access(8'h10, 8'hAB);
    cmp("R6", "unimpl readback", tdout_o, 8'h00);
    cmp("R6", "lanes untouched", lane_ctrl_o, 32'h807E335A);
    cmp("R6", "clk untouched", clk_lane_ctrl_o, 8'h11);

    // R10: back to normal
    access(8'h00, 8'h00);
    cmp("R10", "normal after code 0", normal_o, 1);

    // R9: clear
    latch_code(8'h94);
    tck_i = 1'b1; ten_i = 1'b0; settle_wait();
    tclr_i = 1'b1; settle_wait();
    cmp("R9", "lanes cleared", lane_ctrl_o, 0);
    cmp("R9", "clk cleared", clk_lane_ctrl_o, 8'h00);
    cmp("R9", "settle cleared", settle_ctrl_o, 8'h00);
    cmp("R9", "code cleared", normal_o, 1);
    tclr_i = 1'b0; settle_wait();
    access(8'h84, 8'hC3);
    cmp("R3", "write after clear", lane_ctrl_o[23:16], 8'hC3);
    cmp("R8", "freq after clear", lane_freq_o[17:12], 6'h21);

    settle_wait();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule